// File: doc/BRIEF.md
# Command Queue Register-Write Executor

The block takes 64-bit command words from a stream, each tagged with the thread it belongs to, and turns them into 32-bit register writes on a simple memory-mapped write port. It handles one instruction at a time. A write gets the upper 16 bits of its target address in one of two ways. A direct write carries a small subsystem number, and a programmable table turns that number into the upper half. An indirect write names one of four private scratch registers of its thread. An earlier ASSIGN instruction loads that register, and its content becomes the upper half.

A base loaded once into a scratch register stays there and serves any number of later writes to different offsets. The subsystem table keeps a valid flag for each entry. A write through an invalid entry, or any instruction the block does not support, sets a sticky error bit for the issuing thread and causes no bus write. Instruction layout: opcode [63:56], selector (subsystem number or scratch index or sub-operation) [55:51], indirect flag [50], offset [47:32], value [31:0]. Bits [49:48] are ignored.

Top module: `cmdq_wr_exec`

## Requirements
- R1: After reset `wr_valid` is 0, `in_ready` is 1, `err_flags` is all zero, and every scratch register of every thread reads 0. An indirect write issued before any ASSIGN therefore targets address `{16'h0000, offset}`.
- R2: A WRITE (opcode 0x90) with indirect flag 0 whose table entry is valid drives `wr_addr = {table[selector], offset}` and `wr_data = value`. `wr_valid` rises on the clock edge that accepts the instruction. For example, selector 3 mapped to 0x1C00 with offset 0x002C and value 0x0000000F gives address 0x1C00002C.
- R3: A direct WRITE whose table entry is invalid sets `err_flags[thread]` and produces no write. After reset every table entry is invalid.
- R4: A LOGIC instruction (opcode 0xA0) with selector 0 (ASSIGN), argument-type nibble [47:44] = 0x8 and register index [43:40] in 0..3 loads value[15:0] into that scratch register of the issuing thread. It produces no write.
- R5: A WRITE with indirect flag 1 and selector 0..3 drives `wr_addr = {scratch[thread][selector], offset}` and `wr_data = value`.
- R6: An ASSIGN changes only the named register of the issuing thread. No other thread's scratch registers change.
- R7: A scratch value persists, so one ASSIGN serves several following indirect writes to different offsets.
- R8: While `wr_valid` is 1 and `wr_ready` is 0, `wr_valid`, `wr_addr` and `wr_data` hold, and `in_ready` is 0 so no instruction is accepted. The pending write leaves on the first edge with `wr_ready` high.
- R9: Certain instructions are unsupported: any other opcode, a LOGIC with a selector other than 0, an argument type other than 0x8 or an index above 3, and an indirect WRITE with a selector above 3. Each one sets the sticky `err_flags[thread]` bit, produces no write and changes no scratch register. Error bits never clear except at reset.
- R10: A pulse on `cfg_we` writes `cfg_hi` and the valid flag `cfg_ok` into table entry `cfg_idx`. Writing `cfg_ok = 0` makes that entry invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Instruction can be taken |
| in_tid | input | 5 | Issuing thread number |
| in_word | input | 64 | Instruction word |
| cfg_we | input | 1 | Table entry write strobe |
| cfg_idx | input | 5 | Table entry index |
| cfg_hi | input | 16 | Upper address half for the entry |
| cfg_ok | input | 1 | Entry valid flag |
| wr_valid | output | 1 | Register write pending |
| wr_addr | output | 32 | Write address |
| wr_data | output | 32 | Write data |
| wr_ready | input | 1 | Write port accepts |
| err_flags | output | 32 | Sticky error bit per thread |

## Verification
Scratch state cannot be read directly. A wrong scratch value, or a write landing in the wrong thread's bank, shows up only when an indirect write from that thread reaches `wr_addr`. That address appears one edge after the write is accepted. The bench therefore loads a distinct value into every register of every thread before reading any of them back, so any cross-thread corruption is caught. A wrong table entry or a missed error shows up on `wr_addr` or `err_flags` one edge after the instruction is accepted.

// File: rtl/cmdq_pkg.sv
package cmdq_pkg;

  localparam logic [7:0] OP_WRITE   = 8'h90;
  localparam logic [7:0] OP_LOGIC   = 8'hA0;
  localparam logic [4:0] SUB_ASSIGN = 5'd0;
  localparam logic [3:0] ARG_IMM    = 4'h8;

  typedef enum logic [1:0] {
    K_BAD      = 2'd0,
    K_DIRECT   = 2'd1,
    K_INDIRECT = 2'd2,
    K_ASSIGN   = 2'd3
  } kind_e;

  function automatic logic [7:0] f_opcode(input logic [63:0] w);
    return w[63:56];
  endfunction

  function automatic logic [4:0] f_select(input logic [63:0] w);
    return w[55:51];
  endfunction

  function automatic logic f_indirect(input logic [63:0] w);
    return w[50];
  endfunction

  function automatic logic [15:0] f_offset(input logic [63:0] w);
    return w[47:32];
  endfunction

  function automatic logic [3:0] f_argtype(input logic [63:0] w);
    return w[47:44];
  endfunction

  function automatic logic [3:0] f_regidx(input logic [63:0] w);
    return w[43:40];
  endfunction

  function automatic logic [31:0] f_value(input logic [63:0] w);
    return w[31:0];
  endfunction

  function automatic logic [31:0] form_addr(input logic [15:0] hi, input logic [15:0] off);
    return {hi, off};
  endfunction

endpackage

// File: rtl/cmdq_decode.sv
module cmdq_decode
  import cmdq_pkg::*;
#(
  parameter int NSPR = 4
) (
  input  logic [63:0] word,
  output kind_e       kind,
  output logic [4:0]  sel,
  output logic [3:0]  idx,
  output logic [15:0] off,
  output logic [31:0] val
);

  localparam logic [4:0] NSPR_S = 5'(NSPR);
  localparam logic [3:0] NSPR_I = 4'(NSPR);

  assign sel = f_select(word);
  assign idx = f_regidx(word);
  assign off = f_offset(word);
  assign val = f_value(word);

  always_comb begin
    kind = K_BAD;
    if (f_opcode(word) == OP_WRITE) begin
      if (!f_indirect(word))    kind = K_DIRECT;
      else if (sel < NSPR_S)    kind = K_INDIRECT;
    end else if (f_opcode(word) == OP_LOGIC) begin
      if (sel == SUB_ASSIGN && f_argtype(word) == ARG_IMM && idx < NSPR_I)
        kind = K_ASSIGN;
    end
  end

endmodule

// File: rtl/cmdq_subsys_lut.sv
module cmdq_subsys_lut #(
  parameter int ENTRIES = 32,
  parameter int HI_W    = 16,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [IDX_W-1:0] cfg_idx,
  input  logic [HI_W-1:0]  cfg_hi,
  input  logic             cfg_ok,
  input  logic [4:0]       rd_sel,
  output logic [HI_W-1:0]  rd_hi,
  output logic             rd_ok
);

  logic [HI_W-1:0]    ent_hi [ENTRIES];
  logic [ENTRIES-1:0] ent_ok;
  logic               in_range;
  logic [IDX_W-1:0]   rd_idx;

  assign in_range = (32'(rd_sel) < ENTRIES);
  assign rd_idx   = rd_sel[IDX_W-1:0];
  assign rd_hi    = ent_hi[rd_idx];
  assign rd_ok    = in_range && ent_ok[rd_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) ent_hi[i] <= '0;
      ent_ok <= '0;
    end else if (cfg_we) begin
      ent_hi[cfg_idx] <= cfg_hi;
      ent_ok[cfg_idx] <= cfg_ok;
    end
  end

  AST_LUT_PROG: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (ent_ok[$past(cfg_idx)] == $past(cfg_ok))); // R10

endmodule

// File: rtl/cmdq_spr_file.sv
module cmdq_spr_file #(
  parameter int THREADS = 32,
  parameter int NSPR    = 4,
  parameter int W       = 16,
  localparam int TID_W  = (THREADS > 1) ? $clog2(THREADS) : 1,
  localparam int SI_W   = (NSPR > 1) ? $clog2(NSPR) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TID_W-1:0] tid,
  input  logic             we,
  input  logic [SI_W-1:0]  wr_idx,
  input  logic [W-1:0]     wr_data,
  input  logic [SI_W-1:0]  rd_idx,
  output logic [W-1:0]     rd_data
);

  logic [THREADS-1:0]                 thr_we;
  logic [THREADS-1:0][NSPR-1:0][W-1:0] flat;

  for (genvar t = 0; t < THREADS; t++) begin : g_thr
    logic [NSPR-1:0][W-1:0] bank;
    assign thr_we[t] = we && (tid == TID_W'(t));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         bank <= '0;
      else if (thr_we[t]) bank[wr_idx] <= wr_data;
    end
    assign flat[t] = bank;
  end

  assign rd_data = flat[tid][rd_idx];

  AST_SPR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(thr_we)); // R6
  AST_SPR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(flat)); // R9

endmodule

// File: rtl/cmdq_wr_exec.sv
module cmdq_wr_exec
  import cmdq_pkg::*;
#(
  parameter int THREADS  = 32,
  parameter int NSPR     = 4,
  parameter int SUBSYS_N = 32,
  localparam int TID_W   = (THREADS > 1) ? $clog2(THREADS) : 1,
  localparam int LUT_W   = (SUBSYS_N > 1) ? $clog2(SUBSYS_N) : 1,
  localparam int SI_W    = (NSPR > 1) ? $clog2(NSPR) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [TID_W-1:0]   in_tid,
  input  logic [63:0]        in_word,
  input  logic               cfg_we,
  input  logic [LUT_W-1:0]   cfg_idx,
  input  logic [15:0]        cfg_hi,
  input  logic               cfg_ok,
  output logic               wr_valid,
  output logic [31:0]        wr_addr,
  output logic [31:0]        wr_data,
  input  logic               wr_ready,
  output logic [THREADS-1:0] err_flags
);

  kind_e        kind;
  logic [4:0]   sel;
  logic [3:0]   ridx;
  logic [15:0]  off;
  logic [31:0]  val;
  logic [15:0]  lut_hi;
  logic         lut_ok;
  logic [15:0]  spr_hi;
  logic [15:0]  hi_pick;

  logic         wv_q;
  logic [31:0]  addr_q;
  logic [31:0]  data_q;
  logic [THREADS-1:0] err_q;

  logic         accept;
  logic         issue;
  logic         fire_err;
  logic         spr_we;
  logic         drain;

  cmdq_decode #(.NSPR(NSPR)) u_dec (
    .word (in_word),
    .kind (kind),
    .sel  (sel),
    .idx  (ridx),
    .off  (off),
    .val  (val)
  );

  cmdq_subsys_lut #(.ENTRIES(SUBSYS_N), .HI_W(16)) u_lut (
    .clk     (clk),
    .rst_n   (rst_n),
    .cfg_we  (cfg_we),
    .cfg_idx (cfg_idx),
    .cfg_hi  (cfg_hi),
    .cfg_ok  (cfg_ok),
    .rd_sel  (sel),
    .rd_hi   (lut_hi),
    .rd_ok   (lut_ok)
  );

  cmdq_spr_file #(.THREADS(THREADS), .NSPR(NSPR), .W(16)) u_spr (
    .clk     (clk),
    .rst_n   (rst_n),
    .tid     (in_tid),
    .we      (spr_we),
    .wr_idx  (ridx[SI_W-1:0]),
    .wr_data (val[15:0]),
    .rd_idx  (sel[SI_W-1:0]),
    .rd_data (spr_hi)
  );

  assign in_ready = !wv_q;
  assign accept   = in_valid && in_ready;
  assign drain    = wv_q && wr_ready;
  assign hi_pick  = (kind == K_INDIRECT) ? spr_hi : lut_hi;
  assign issue    = accept && ((kind == K_INDIRECT) || (kind == K_DIRECT && lut_ok));
  assign fire_err = accept && ((kind == K_BAD) || (kind == K_DIRECT && !lut_ok));
  assign spr_we   = accept && (kind == K_ASSIGN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wv_q   <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
      err_q  <= '0;
    end else begin
      if (drain) wv_q <= 1'b0;
      if (issue) begin
        wv_q   <= 1'b1;
        addr_q <= form_addr(hi_pick, off);
        data_q <= val;
      end
      if (fire_err) err_q[in_tid] <= 1'b1;
    end
  end

  assign wr_valid  = wv_q;
  assign wr_addr   = addr_q;
  assign wr_data   = data_q;
  assign err_flags = err_q;

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    wv_q && !wr_ready |=> wv_q && $stable(addr_q) && $stable(data_q)); // R8
  AST_ISSUE_SHOWS: assert property (@(posedge clk) disable iff (!rst_n)
    issue |=> wr_valid); // R2
  AST_ERR_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    fire_err |=> !wr_valid); // R3
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q & $past(err_q)) == $past(err_q)); // R9
  AST_ERR_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(err_q ^ $past(err_q)) <= 1); // R9

endmodule

// File: tb/sim_cmdq_wr_exec.sv
`timescale 1ns/1ps
module sim_cmdq_wr_exec;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [4:0]  in_tid = '0;
  logic [63:0] in_word = '0;
  logic        cfg_we = 1'b0;
  logic [4:0]  cfg_idx = '0;
  logic [15:0] cfg_hi = '0;
  logic        cfg_ok = 1'b0;
  logic        wr_valid;
  logic [31:0] wr_addr;
  logic [31:0] wr_data;
  logic        wr_ready = 1'b1;
  logic [31:0] err_flags;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;
  logic [31:0] exp_err = '0;

  always #2.5 clk = ~clk;

  cmdq_wr_exec u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_tid(in_tid), .in_word(in_word), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_hi(cfg_hi), .cfg_ok(cfg_ok), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_ready(wr_ready), .err_flags(err_flags)
  );

  function automatic logic [63:0] w_write(input logic [4:0] s, input logic ind,
                                          input logic [15:0] o, input logic [31:0] v);
    return {8'h90, s, ind, 2'b00, o, v};
  endfunction

  function automatic logic [63:0] w_assign(input logic [4:0] sub, input logic [3:0] arg,
                                           input logic [3:0] idx, input logic [15:0] imm);
    return {8'hA0, sub, 1'b0, 2'b00, arg, idx, 8'h00, 16'h0000, imm};
  endfunction

  function automatic logic [15:0] lut_val(input int i);
    return (i == 3) ? 16'h1C00 : 16'h4000 + 16'(i) * 16'h0111;
  endfunction

  function automatic logic [15:0] spr_val(input int t, input int s);
    return 16'h8000 | 16'(t << 8) | 16'(s << 4) | 16'h0003;
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [4:0] t, input logic [63:0] w);
    @(negedge clk);
    in_tid = t; in_word = w; in_valid = 1'b1;
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  task automatic expect_wr(input string tag, input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    check(tag, {31'b0, wr_valid, wr_addr}, {31'b0, 1'b1, a});
    check(tag, {32'b0, wr_data}, {32'b0, d});
  endtask

  task automatic expect_none(input string tag);
    @(negedge clk);
    check(tag, {63'b0, wr_valid}, 64'd0);
    check({tag, " err"}, {32'b0, err_flags}, {32'b0, exp_err});
  endtask

  task automatic prog(input int i, input logic [15:0] h, input logic ok);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 5'(i); cfg_hi = h; cfg_ok = ok;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset valid/ready", {62'b0, wr_valid, in_ready}, 64'd1);
    check("R1 reset err", {32'b0, err_flags}, 64'd0);
    send(5'd9, w_write(5'd2, 1'b1, 16'h1234, 32'hAAAA5555));
    expect_wr("R1 scratch zero after reset", 32'h00001234, 32'hAAAA5555);

    // R3: empty table rejects direct writes
    send(5'd1, w_write(5'd3, 1'b0, 16'h002C, 32'h1));
    exp_err[1] = 1'b1;
    expect_none("R3 invalid after reset");

    // R10: program all, then invalidate every third
    for (int i = 0; i < 32; i++) prog(i, lut_val(i), 1'b1);
    for (int i = 2; i < 32; i += 3) prog(i, 16'hFFFF, 1'b0);

    send(5'd0, w_write(5'd3, 1'b0, 16'h002C, 32'h0000000F));
    expect_wr("R2 example direct", 32'h1C00002C, 32'h0000000F);

    for (int i = 0; i < 32; i++) begin
      send(5'(i), w_write(5'(i), 1'b0, 16'(i * 64 + 44), 32'hC0DE0000 | 32'(i)));
      if (i % 3 == 2) begin
        exp_err[i] = 1'b1;
        expect_none("R3/R10 invalidated entry");
      end else begin
        expect_wr("R2/R10 direct sweep", {lut_val(i), 16'(i * 64 + 44)}, 32'hC0DE0000 | 32'(i));
      end
    end

    // R4/R6: load every scratch register of every thread, then read all back
    for (int t = 0; t < 32; t++)
      for (int s = 0; s < 4; s++) begin
        send(5'(t), w_assign(5'd0, 4'h8, 4'(s), spr_val(t, s)));
        if (t == 31 && s == 3) expect_none("R4 assign no write");
      end
    for (int t = 0; t < 32; t++)
      for (int s = 0; s < 4; s++) begin
        send(5'(t), w_write(5'(s), 1'b1, 16'(s * 256 + t), 32'(t * 4 + s)));
        expect_wr("R5/R6 indirect sweep", {spr_val(t, s), 16'(s * 256 + t)}, 32'(t * 4 + s));
      end

    // R7: one base, several offsets
    send(5'd4, w_assign(5'd0, 4'h8, 4'd1, 16'h1C01));
    for (int k = 0; k < 3; k++) begin
      send(5'd4, w_write(5'd1, 1'b1, 16'(16'h002C + k * 16), 32'(100 + k)));
      expect_wr("R7 persistent base", {16'h1C01, 16'(16'h002C + k * 16)}, 32'(100 + k));
    end

    // R8: back-pressure holds the write and blocks input
    @(negedge clk); wr_ready = 1'b0;
    send(5'd0, w_write(5'd0, 1'b0, 16'h0AA0, 32'hDEADBEEF));
    @(negedge clk);
    in_tid = 5'd0; in_word = w_write(5'd1, 1'b0, 16'h0BB0, 32'h12345678); in_valid = 1'b1;
    for (int k = 0; k < 3; k++) begin
      check("R8 hold addr", {31'b0, wr_valid, wr_addr}, {31'b0, 1'b1, lut_val(0), 16'h0AA0});
      check("R8 hold data/ready", {31'b0, in_ready, wr_data}, {32'b0, 32'hDEADBEEF});
      @(negedge clk);
    end
    wr_ready = 1'b1;
    @(posedge clk);
    @(posedge clk);
    #1 in_valid = 1'b0;
    expect_wr("R8 queued instruction after drain", {lut_val(1), 16'h0BB0}, 32'h12345678);

    // R9: unsupported forms
    send(5'd31, {8'h55, 56'h0});
    exp_err[31] = 1'b1;
    expect_none("R9 bad opcode");
    send(5'd30, w_assign(5'd1, 4'h8, 4'd0, 16'hFFFF));
    exp_err[30] = 1'b1;
    expect_none("R9 bad logic subop");
    send(5'd30, w_write(5'd0, 1'b1, 16'h0010, 32'h7));
    expect_wr("R9 scratch unchanged after bad subop", {spr_val(30, 0), 16'h0010}, 32'h7);
    send(5'd27, w_assign(5'd0, 4'h4, 4'd2, 16'hFFFF));
    exp_err[27] = 1'b1;
    expect_none("R9 bad arg type");
    send(5'd27, w_write(5'd2, 1'b1, 16'h0020, 32'h9));
    expect_wr("R9 scratch unchanged after bad arg", {spr_val(27, 2), 16'h0020}, 32'h9);
    send(5'd28, w_write(5'd5, 1'b1, 16'h0, 32'h0));
    exp_err[28] = 1'b1;
    expect_none("R9 bad scratch selector");
    send(5'd28, w_write(5'd0, 1'b0, 16'h0030, 32'h3));
    expect_wr("R9 sticky after good write", {lut_val(0), 16'h0030}, 32'h3);
    @(negedge clk);
    check("R9 sticky flags", {32'b0, err_flags}, {32'b0, exp_err});

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

endmodule